// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers single-cycle event pulses from a peripheral's sources into sticky pending bits and gives a host a small register window onto them. A per-source mask register decides which pending events are visible in the main status view and which may drive the single active-high interrupt request line. Events whose mask bit is set are kept pending, hidden from reads, and show up as soon as software clears that mask bit.

A second, auxiliary status register latches three housekeeping events: a timer expiry, a watchdog overflow and an external wake. Any pending auxiliary event appears in the main view as one summary bit, and that summary bit obeys its own mask bit. The channel-change source is handled differently from the other main sources. It always appears in the status view, but it may request an interrupt only while its mask bit is clear.

The host reaches both registers through a one-bit select. A read of the main select returns the status view, and a write to the main select loads the mask. Reads clear the bits they return as 1.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset the mask register is all ones, the main and auxiliary views read 0x00, and `irq_o` is low. With the reset mask, events on any source leave `irq_o` low.
- R2: A write with `bus_sel_i`=0 loads `bus_wdata_i` into the mask. A mask bit of 0 enables its source and a mask bit of 1 disables it.
- R3: A one-cycle pulse on a source input sets that source's pending bit, and the bit stays set until it is cleared by a read.
- R4: A main read (`bus_sel_i`=0) shows source k (`ev_src_i[k]`) on bit k only when mask bit k is 0. Masked source bits read as 0.
- R5: A masked pending source bit is never cleared by a read. It appears in the main view once its mask bit is written to 0.
- R6: The channel-change event is shown on bit NUM_EV+1 (bit 7 by default) whatever its mask bit is. It raises `irq_o` only while that mask bit is 0. A main read that returns it as 1 clears it.
- R7: `irq_o` is high exactly when some pending bit (or the auxiliary summary) has a 0 mask bit. It follows the pending state one clock later.
- R8: A main read clears every bit it returns as 1, at the clock edge that ends the read. An event arriving in the same cycle as the read leaves its bit set.
- R9: An auxiliary read (`bus_sel_i`=1) returns timer on bit 0, watchdog on bit 1 and wake on bit 2. It clears the bits it returns as 1, except for a bit whose event arrives in that same cycle.
- R10: Main bit NUM_EV (bit 6 by default) is the summary of any pending auxiliary bit, gated by mask bit 6. It is not cleared by a main read, only by an auxiliary read that empties the auxiliary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous release |
| ev_src_i | input | NUM_EV | General event pulses, one per source |
| chg_ev_i | input | 1 | Channel-change event pulse |
| tmr_ev_i | input | 1 | Timer expiry event pulse |
| wdog_ev_i | input | 1 | Watchdog overflow event pulse |
| wake_ev_i | input | 1 | External wake event pulse |
| bus_sel_i | input | 1 | Register select: 0 main status/mask, 1 auxiliary |
| bus_rd_i | input | 1 | Read strobe, one cycle per read |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | NUM_EV+2 | Write data (mask value) |
| bus_rdata_o | output | NUM_EV+2 | Read data, valid while `bus_rd_i` is high, zero otherwise |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The vector walk combines different masks with general events, the channel-change event and auxiliary events. Each row shows whether hiding and interrupt gating follow each mask bit on its own. Some rows mask every source, so they show whether the channel-change bit is the only one that still shows without raising the line. Directed sequences read masked bits repeatedly and then unmask them, which tells a held pending bit apart from a discarded one. Others collide an event with a read of its own register, which tells a correct clear from one that loses the new event. The summary bit is read from both registers to show that only the auxiliary read drains it.

// File: rtl/irq_pkg.sv
package irq_pkg;
   localparam int AUX_W     = 3;
   localparam int AUX_TMR   = 0;
   localparam int AUX_WDOG  = 1;
   localparam int AUX_WAKE  = 2;

   typedef enum logic {
      SEL_MAIN = 1'b0,
      SEL_AUX  = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q_r;

   if (W < 1) begin : g_bad_w
      $error("irq_sticky_bank: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q_r <= '0;
      else        q_r <= (q_r & ~clr_i) | set_i;
   end

   assign q_o = q_r;

   for (genvar i = 0; i < W; i++) begin : g_chk
      AST_EVENT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q_r[i]); // R3
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we_i,
   input  logic [W-1:0] wdata_i,
   output logic [W-1:0] mask_o
);
   logic [W-1:0] mask_r;

   always_ff @(posedge clk) begin
      if (!rst_n)    mask_r <= '1;
      else if (we_i) mask_r <= wdata_i;
   end

   assign mask_o = mask_r;

   AST_MASK_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (mask_r == $past(wdata_i))); // R2
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
   import irq_pkg::*;
#(
   parameter int NUM_EV  = 6,
   parameter bit IRQ_REG = 1'b1,
   localparam int REG_W  = NUM_EV + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_EV-1:0] ev_src_i,
   input  logic             chg_ev_i,
   input  logic             tmr_ev_i,
   input  logic             wdog_ev_i,
   input  logic             wake_ev_i,
   input  logic             bus_sel_i,
   input  logic             bus_rd_i,
   input  logic             bus_wr_i,
   input  logic [REG_W-1:0] bus_wdata_i,
   output logic [REG_W-1:0] bus_rdata_o,
   output logic             irq_o
);
   localparam int AUX_BIT = NUM_EV;
   localparam int CHG_BIT = NUM_EV + 1;
   localparam int PM_W    = NUM_EV + 1;

   if (NUM_EV < 1 || NUM_EV > 30) begin : g_bad_num
      $error("irq_status_ctrl: NUM_EV must be within 1..30");
   end

   logic             rd_main, rd_aux, wr_main;
   logic [REG_W-1:0] mask_q;
   logic [PM_W-1:0]  pm_set, pm_clr, pm_q;
   logic [AUX_W-1:0] aux_set, aux_clr, aux_q;
   logic             aux_any;
   logic [REG_W-1:0] view;
   logic             irq_next;

   assign rd_main = bus_rd_i && (reg_sel_e'(bus_sel_i) == SEL_MAIN);
   assign rd_aux  = bus_rd_i && (reg_sel_e'(bus_sel_i) == SEL_AUX);
   assign wr_main = bus_wr_i && (reg_sel_e'(bus_sel_i) == SEL_MAIN);

   irq_mask_reg #(.W(REG_W)) mask_i (
      .clk(clk), .rst_n(rst_n), .we_i(wr_main),
      .wdata_i(bus_wdata_i), .mask_o(mask_q)
   );

   // main pending bank: general sources then channel change on top
   assign pm_set = {chg_ev_i, ev_src_i};
   assign pm_clr = rd_main ? {view[CHG_BIT], view[NUM_EV-1:0]} : '0;

   irq_sticky_bank #(.W(PM_W)) main_bank_i (
      .clk(clk), .rst_n(rst_n), .set_i(pm_set), .clr_i(pm_clr), .q_o(pm_q)
   );

   always_comb begin
      aux_set           = '0;
      aux_set[AUX_TMR]  = tmr_ev_i;
      aux_set[AUX_WDOG] = wdog_ev_i;
      aux_set[AUX_WAKE] = wake_ev_i;
   end
   assign aux_clr = rd_aux ? aux_q : '0;

   irq_sticky_bank #(.W(AUX_W)) aux_bank_i (
      .clk(clk), .rst_n(rst_n), .set_i(aux_set), .clr_i(aux_clr), .q_o(aux_q)
   );

   assign aux_any = |aux_q;

   always_comb begin
      view                 = '0;
      view[NUM_EV-1:0]     = pm_q[NUM_EV-1:0] & ~mask_q[NUM_EV-1:0];
      view[AUX_BIT]        = aux_any & ~mask_q[AUX_BIT];
      view[CHG_BIT]        = pm_q[NUM_EV];
   end

   always_comb begin
      if (rd_main)     bus_rdata_o = view;
      else if (rd_aux) bus_rdata_o = {{(REG_W-AUX_W){1'b0}}, aux_q};
      else             bus_rdata_o = '0;
   end

   assign irq_next = (|view[NUM_EV:0]) | (pm_q[NUM_EV] & ~mask_q[CHG_BIT]);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_r;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_r <= 1'b0;
         else        irq_r <= irq_next;
      end
      assign irq_o = irq_r;

      AST_CHG_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
         (mask_q[CHG_BIT] && !(|(pm_q[NUM_EV-1:0] & ~mask_q[NUM_EV-1:0]))
          && !(aux_any && !mask_q[AUX_BIT])) |=> !irq_o); // R6
   end else begin : g_irq_comb
      assign irq_o = irq_next;
   end

   for (genvar i = 0; i < NUM_EV; i++) begin : g_main_chk
      AST_MASKED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         (pm_q[i] && mask_q[i]) |=> pm_q[i]); // R5
   end

   for (genvar j = 0; j < AUX_W; j++) begin : g_aux_chk
      AST_AUX_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_aux && aux_q[j] && !aux_set[j]) |=> !aux_q[j]); // R9
   end
endmodule

// File: tb/irq_status_ctrl_tb_top.sv
module irq_status_ctrl_tb_top;
   localparam int NUM_EV = 6;
   localparam int REG_W  = NUM_EV + 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NUM_EV-1:0] ev_src = '0;
   logic chg_ev = 1'b0, tmr_ev = 1'b0, wdog_ev = 1'b0, wake_ev = 1'b0;
   logic bus_sel = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
   logic [REG_W-1:0] bus_wdata = '0;
   logic [REG_W-1:0] bus_rdata;
   logic irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_status_ctrl #(.NUM_EV(NUM_EV), .IRQ_REG(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ev_src_i(ev_src), .chg_ev_i(chg_ev),
      .tmr_ev_i(tmr_ev), .wdog_ev_i(wdog_ev), .wake_ev_i(wake_ev),
      .bus_sel_i(bus_sel), .bus_rd_i(bus_rd), .bus_wr_i(bus_wr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_o(irq)
   );

   typedef struct packed {
      logic [7:0] mask;
      logic [5:0] ev;
      logic       chg;
      logic [2:0] aux;   // {wake, wdog, tmr}
      logic [7:0] exp_rd;
      logic       exp_irq;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{8'h00, 6'h05, 1'b0, 3'b000, 8'h05, 1'b1},
      '{8'hFF, 6'h3F, 1'b0, 3'b000, 8'h00, 1'b0},
      '{8'hFF, 6'h00, 1'b1, 3'b000, 8'h80, 1'b0},
      '{8'h7F, 6'h00, 1'b1, 3'b000, 8'h80, 1'b1},
      '{8'hF0, 6'h3C, 1'b0, 3'b000, 8'h0C, 1'b1},
      '{8'hBF, 6'h00, 1'b0, 3'b010, 8'h40, 1'b1},
      '{8'hFF, 6'h00, 1'b0, 3'b111, 8'h00, 1'b0},
      '{8'h3F, 6'h21, 1'b1, 3'b001, 8'hC0, 1'b1}
   };

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr_mask(input logic [7:0] m);
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = m;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   // read; optional events raised in the same cycle
   task automatic rd_reg(input logic sel, input logic [5:0] ev, input logic [2:0] aux,
                         output logic [7:0] d);
      @(negedge clk);
      bus_sel = sel; bus_rd = 1'b1;
      ev_src = ev; tmr_ev = aux[0]; wdog_ev = aux[1]; wake_ev = aux[2];
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; ev_src = '0; tmr_ev = 1'b0; wdog_ev = 1'b0; wake_ev = 1'b0;
   endtask

   // pulse events for one cycle, then leave one cycle for the registered request
   task automatic pulse(input logic [5:0] ev, input logic c, input logic [2:0] aux);
      @(negedge clk);
      ev_src = ev; chg_ev = c; tmr_ev = aux[0]; wdog_ev = aux[1]; wake_ev = aux[2];
      @(negedge clk);
      ev_src = '0; chg_ev = 1'b0; tmr_ev = 1'b0; wdog_ev = 1'b0; wake_ev = 1'b0;
      @(negedge clk);
   endtask

   task automatic drain();
      logic [7:0] d;
      wr_mask(8'h00);
      rd_reg(1'b1, '0, '0, d);
      rd_reg(1'b0, '0, '0, d);
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [7:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq after reset", {7'b0, irq}, 8'h00);
      rd_reg(1'b0, '0, '0, d); chk("R1 main view after reset", d, 8'h00);
      rd_reg(1'b1, '0, '0, d); chk("R1 aux view after reset", d, 8'h00);
      pulse(6'h3F, 1'b0, 3'b000);
      chk("R1 reset mask blocks irq", {7'b0, irq}, 8'h00);
      rd_reg(1'b0, '0, '0, d); chk("R1 reset mask hides sources", d, 8'h00);
      drain();

      // vector walk: R2 R3 R4 R6 R7 R10
      for (int i = 0; i < 8; i++) begin
         wr_mask(VECS[i].mask);
         pulse(VECS[i].ev, VECS[i].chg, VECS[i].aux);
         chk($sformatf("R7 irq vector %0d", i), {7'b0, irq}, {7'b0, VECS[i].exp_irq});
         rd_reg(1'b0, '0, '0, d);
         chk($sformatf("R4 main view vector %0d", i), d, VECS[i].exp_rd);
         drain();
      end

      // R5 masked bit survives reads, appears on unmask; R8 cleared after shown
      wr_mask(8'hFF);
      pulse(6'h01, 1'b0, 3'b000);
      rd_reg(1'b0, '0, '0, d); chk("R5 masked read 1", d, 8'h00);
      rd_reg(1'b0, '0, '0, d); chk("R5 masked read 2", d, 8'h00);
      wr_mask(8'hFE);
      @(negedge clk);
      chk("R2 unmask raises irq", {7'b0, irq}, 8'h01);
      rd_reg(1'b0, '0, '0, d); chk("R5 appears after unmask", d, 8'h01);
      rd_reg(1'b0, '0, '0, d); chk("R8 cleared by read", d, 8'h00);
      @(negedge clk);
      chk("R7 irq drops after clear", {7'b0, irq}, 8'h00);
      drain();

      // R8 event colliding with read stays set
      wr_mask(8'h00);
      pulse(6'h02, 1'b0, 3'b000);
      rd_reg(1'b0, 6'h02, '0, d); chk("R8 read returns bit", d, 8'h02);
      rd_reg(1'b0, '0, '0, d); chk("R8 same-cycle event kept", d, 8'h02);
      drain();

      // R6 masked channel change shown, no irq, cleared by read
      wr_mask(8'hFF);
      pulse(6'h00, 1'b1, 3'b000);
      chk("R6 masked chg no irq", {7'b0, irq}, 8'h00);
      rd_reg(1'b0, '0, '0, d); chk("R6 masked chg shown", d, 8'h80);
      rd_reg(1'b0, '0, '0, d); chk("R6 chg cleared by read", d, 8'h00);
      drain();

      // R9 aux clear on read, same-cycle retention
      pulse(6'h00, 1'b0, 3'b010);
      rd_reg(1'b1, '0, '0, d); chk("R9 watchdog bit", d, 8'h02);
      rd_reg(1'b1, '0, '0, d); chk("R9 aux cleared", d, 8'h00);
      pulse(6'h00, 1'b0, 3'b001);
      rd_reg(1'b1, '0, 3'b001, d); chk("R9 timer bit", d, 8'h01);
      rd_reg(1'b1, '0, '0, d); chk("R9 same-cycle timer kept", d, 8'h01);
      drain();

      // R10 summary survives main read, drained by aux read
      wr_mask(8'h00);
      pulse(6'h00, 1'b0, 3'b100);
      rd_reg(1'b0, '0, '0, d); chk("R10 summary shown", d, 8'h40);
      rd_reg(1'b0, '0, '0, d); chk("R10 summary kept after main read", d, 8'h40);
      rd_reg(1'b1, '0, '0, d); chk("R10 wake bit in aux", d, 8'h04);
      rd_reg(1'b0, '0, '0, d); chk("R10 summary gone after aux read", d, 8'h00);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule